// File: doc/BRIEF.md
# Log-Domain Gaussian Observation Scorer

This block scores one speech feature vector against every state of a set of diagonal-covariance Gaussian models. It works in the negative-log domain, so each state's score is a weighted sum of squared distances plus a constant that depends only on the state. A frame begins with a load phase: the block takes the observation vector one element per clock and keeps it in a local vector buffer. In the scoring phase the model parameters stream in one beat per clock. Each state has one beat per feature, carrying a mean and a precomputed weight equal to 1/(2·variance). After those comes one extra beat that carries the state's constant term. The stored vector is replayed for every state, so it is fetched only once per frame.

The datapath has three pipeline stages: difference, square, and weight with constant bypass. A signed fixed-point accumulator follows. The accumulator restarts on the first beat of each state, so states can follow each other with no idle cycle. Each finished sum is shifted down to the output scale, saturated, and written into a score buffer. Only when every state of the frame has been scored does the buffer drain through a valid/ready output, in state order. The first output cycle is marked with a one-cycle frame-done pulse. After the last score is taken, the block returns to the load phase for the next frame.

Top module: `log_gauss_scorer`

## Requirements
- R1: After reset, obs_ready_o is 1, and prm_ready_o, score_valid_o and frame_done_o are 0.
- R2: obs_ready_o stays 1 until N_FEAT observation elements have been accepted, then falls to 0. From then on prm_ready_o is 1 until N_STATES*(N_FEAT+1) parameter beats have been accepted. prm_ready_o is 0 during the load phase, so parameter beats offered then are not consumed.
- R3: Beats are counted from 0 within each state. On beats 0..N_FEAT-1, state s accumulates (x_i - m_i)^2 * w_i, where x_i and m_i are signed and w_i is unsigned. Beat N_FEAT, the final one, adds prm_const_i (signed) directly. prm_const_i is ignored on feature beats, and the mean and weight fields are ignored on the constant beat.
- R4: The output score equals the full sum arithmetically shifted right by OUT_SHIFT (default 8), saturated to a signed SCORE_W-bit value (default 24).
- R5: The vector loaded in the load phase is used for every state of the frame. obs_ready_o is 0 outside the load phase, so observation elements offered then are not consumed.
- R6: Each state's score is independent of the previous state. Cycles with prm_valid_i low do not change any score.
- R7: score_valid_o stays 0 until all N_STATES scores of the frame are complete. Scores are then presented in state order, with score_idx_o equal to 0, 1, ..., N_STATES-1.
- R8: frame_done_o is a single-cycle pulse once per frame. It coincides with the first cycle of score_valid_o, when score_idx_o is 0.
- R9: While score_valid_o is 1 and score_ready_i is 0, score_o and score_idx_o hold their values.
- R10: After the last score is accepted, the block returns to the load phase with obs_ready_o set to 1, and the next frame is scored correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| obs_valid_i | input | 1 | Observation element valid |
| obs_ready_o | output | 1 | Block accepts observation elements (load phase) |
| obs_data_i | input | OBS_W | Signed observation element |
| prm_valid_i | input | 1 | Parameter beat valid |
| prm_ready_o | output | 1 | Block accepts parameter beats (scoring phase) |
| prm_mean_i | input | OBS_W | Signed mean for a feature beat |
| prm_wt_i | input | WT_W | Unsigned weight 1/(2·variance) for a feature beat |
| prm_const_i | input | CONST_W | Signed state constant for the final beat |
| score_valid_o | output | 1 | Buffered score available |
| score_ready_i | input | 1 | Downstream takes the score |
| score_o | output | SCORE_W | Signed saturated score |
| score_idx_o | output | SIDX_W | State index of score_o |
| frame_done_o | output | 1 | Pulse: all state scores of the frame buffered |

## Verification
A corrupted vector buffer entry, a missed accumulator restart, or a mis-timed bypass of the constant beat does not stay hidden. It shows up as a wrong score_o for every state the fault touches, and it is visible as soon as the frame drains, which is a few cycles after the last parameter beat. The bench computes each expected score from the requirement formula and compares every drained score. It uses vectors whose states differ strongly, so that leakage between states shows. A miscounted beat or state counter shows at the handshake ports within the same frame: a ready flag rises or falls at the wrong count, score indices come out of order, or the done pulse does not line up with the first valid score.

// File: rtl/obs_score_pkg.sv
package obs_score_pkg;
  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,
    PH_SCORE = 2'd1,
    PH_WAIT  = 2'd2,
    PH_DRAIN = 2'd3
  } phase_e;
endpackage

// File: rtl/obs_vec_buf.sv
module obs_vec_buf #(
  parameter int N_FEAT = 39,
  parameter int OBS_W  = 12,
  parameter int IDX_W  = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [IDX_W-1:0]        wr_idx_i,
  input  logic signed [OBS_W-1:0] wr_data_i,
  input  logic                    rd_en_i,
  input  logic [IDX_W-1:0]        rd_idx_i,
  output logic signed [OBS_W-1:0] rd_data_o
);
  logic signed [OBS_W-1:0] mem_q [N_FEAT];

  for (genvar g = 0; g < N_FEAT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      mem_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))       mem_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < N_FEAT; k++)
      if (rd_idx_i == IDX_W'(k)) rd_data_o = mem_q[k];
  end

  // vector is never rewritten while it is being replayed
  p_no_wr_during_replay_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && rd_en_i));
  p_wr_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> wr_idx_i < IDX_W'(N_FEAT));
endmodule

// File: rtl/gauss_term_pipe.sv
module gauss_term_pipe #(
  parameter int OBS_W   = 12,
  parameter int WT_W    = 12,
  parameter int CONST_W = 32,
  parameter int TERM_W  = 39,
  parameter int SIDX_W  = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  input  logic signed [OBS_W-1:0]   obs_i,
  input  logic signed [OBS_W-1:0]   mean_i,
  input  logic [WT_W-1:0]           wt_i,
  input  logic signed [CONST_W-1:0] cst_i,
  input  logic                      is_const_i,
  input  logic                      first_i,
  input  logic [SIDX_W-1:0]         sidx_i,
  output logic                      out_valid_o,
  output logic signed [TERM_W-1:0]  term_o,
  output logic                      first_o,
  output logic                      last_o,
  output logic [SIDX_W-1:0]         sidx_o
);
  localparam int DW = OBS_W + 1;
  localparam int SW = 2 * DW;

  // stage 1: difference
  logic                      s1_v, s1_c, s1_f;
  logic [SIDX_W-1:0]         s1_s;
  logic signed [DW-1:0]      s1_d;
  logic [WT_W-1:0]           s1_w;
  logic signed [CONST_W-1:0] s1_k;
  // stage 2: square
  logic                      s2_v, s2_c, s2_f;
  logic [SIDX_W-1:0]         s2_s;
  logic signed [SW-1:0]      s2_sq;
  logic [WT_W-1:0]           s2_w;
  logic signed [CONST_W-1:0] s2_k;
  logic signed [TERM_W-1:0]  term_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v <= 1'b0; s1_c <= 1'b0; s1_f <= 1'b0; s1_s <= '0;
      s1_d <= '0;   s1_w <= '0;   s1_k <= '0;
    end else begin
      s1_v <= in_valid_i;
      if (in_valid_i) begin
        s1_c <= is_const_i;
        s1_f <= first_i;
        s1_s <= sidx_i;
        s1_d <= {obs_i[OBS_W-1], obs_i} - {mean_i[OBS_W-1], mean_i};
        s1_w <= wt_i;
        s1_k <= cst_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_v <= 1'b0; s2_c <= 1'b0; s2_f <= 1'b0; s2_s <= '0;
      s2_sq <= '0;  s2_w <= '0;   s2_k <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_c  <= s1_c;
        s2_f  <= s1_f;
        s2_s  <= s1_s;
        s2_sq <= SW'(s1_d) * SW'(s1_d);
        s2_w  <= s1_w;
        s2_k  <= s1_k;
      end
    end
  end

  // stage 3: weight, or bypass for the constant beat
  always_comb begin
    if (s2_c) term_d = TERM_W'(s2_k);
    else      term_d = TERM_W'(s2_sq) * TERM_W'($signed({1'b0, s2_w}));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0; term_o <= '0; first_o <= 1'b0;
      last_o <= 1'b0; sidx_o <= '0;
    end else begin
      out_valid_o <= s2_v;
      if (s2_v) begin
        term_o  <= term_d;
        first_o <= s2_f;
        last_o  <= s2_c;
        sidx_o  <= s2_s;
      end
    end
  end

  // a squared, weighted feature term is never negative
  p_term_nonneg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !last_o) |-> !term_o[TERM_W-1]);
endmodule

// File: rtl/score_acc.sv
module score_acc #(
  parameter int TERM_W    = 39,
  parameter int ACC_W     = 48,
  parameter int SCORE_W   = 24,
  parameter int OUT_SHIFT = 8,
  parameter int SIDX_W    = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  input  logic signed [TERM_W-1:0]  term_i,
  input  logic                      first_i,
  input  logic                      last_i,
  input  logic [SIDX_W-1:0]         sidx_i,
  output logic                      wr_en_o,
  output logic [SIDX_W-1:0]         wr_idx_o,
  output logic signed [SCORE_W-1:0] wr_score_o
);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((longint'(1) <<< (SCORE_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

  logic signed [ACC_W-1:0]   acc_q, base_d, term_x, sum_d, shr_d;
  logic signed [SCORE_W-1:0] sat_d;

  always_comb begin
    base_d = first_i ? '0 : acc_q;
    term_x = ACC_W'(term_i);
    sum_d  = base_d + term_x;
    shr_d  = sum_d >>> OUT_SHIFT;
    if (shr_d > SAT_HI)      sat_d = SAT_HI[SCORE_W-1:0];
    else if (shr_d < SAT_LO) sat_d = SAT_LO[SCORE_W-1:0];
    else                     sat_d = shr_d[SCORE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= '0;
      wr_en_o    <= 1'b0;
      wr_idx_o   <= '0;
      wr_score_o <= '0;
    end else begin
      wr_en_o <= in_valid_i && last_i;
      if (in_valid_i) acc_q <= sum_d;
      if (in_valid_i && last_i) begin
        wr_idx_o   <= sidx_i;
        wr_score_o <= sat_d;
      end
    end
  end

  // signed accumulation never wraps
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> !((base_d[ACC_W-1] == term_x[ACC_W-1]) &&
                     (sum_d[ACC_W-1] != base_d[ACC_W-1])));
endmodule

// File: rtl/score_buf.sv
module score_buf #(
  parameter int N_STATES = 6,
  parameter int SCORE_W  = 24,
  parameter int SIDX_W   = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [SIDX_W-1:0]         wr_idx_i,
  input  logic signed [SCORE_W-1:0] wr_data_i,
  input  logic [SIDX_W-1:0]         rd_idx_i,
  output logic signed [SCORE_W-1:0] rd_data_o
);
  logic signed [SCORE_W-1:0] mem_q [N_STATES];

  for (genvar g = 0; g < N_STATES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == SIDX_W'(g))    mem_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < N_STATES; k++)
      if (rd_idx_i == SIDX_W'(k)) rd_data_o = mem_q[k];
  end

  p_wr_in_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> wr_idx_i < SIDX_W'(N_STATES));
endmodule

// File: rtl/log_gauss_scorer.sv
module log_gauss_scorer #(
  parameter int N_FEAT    = 39,
  parameter int N_STATES  = 6,
  parameter int OBS_W     = 12,
  parameter int WT_W      = 12,
  parameter int CONST_W   = 32,
  parameter int ACC_W     = 48,
  parameter int SCORE_W   = 24,
  parameter int OUT_SHIFT = 8,
  localparam int SIDX_W   = (N_STATES > 1) ? $clog2(N_STATES) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      obs_valid_i,
  output logic                      obs_ready_o,
  input  logic signed [OBS_W-1:0]   obs_data_i,
  input  logic                      prm_valid_i,
  output logic                      prm_ready_o,
  input  logic signed [OBS_W-1:0]   prm_mean_i,
  input  logic [WT_W-1:0]           prm_wt_i,
  input  logic signed [CONST_W-1:0] prm_const_i,
  output logic                      score_valid_o,
  input  logic                      score_ready_i,
  output logic signed [SCORE_W-1:0] score_o,
  output logic [SIDX_W-1:0]         score_idx_o,
  output logic                      frame_done_o
);
  import obs_score_pkg::*;

  localparam int FIDX_W = $clog2(N_FEAT + 1);
  localparam int TERM_W = 2 * (OBS_W + 1) + WT_W + 1;

  phase_e            phase_q;
  logic [FIDX_W-1:0] load_cnt_q, elem_cnt_q;
  logic [SIDX_W-1:0] st_cnt_q, rd_cnt_q;
  logic              done_q;

  logic obs_fire, prm_fire, out_fire, is_const, first_beat;
  logic last_load, last_state, last_drain;

  logic signed [OBS_W-1:0]   rep_obs;
  logic                      t_valid, t_first, t_last;
  logic signed [TERM_W-1:0]  t_term;
  logic [SIDX_W-1:0]         t_sidx;
  logic                      w_en;
  logic [SIDX_W-1:0]         w_idx;
  logic signed [SCORE_W-1:0] w_score;

  assign obs_ready_o   = (phase_q == PH_LOAD);
  assign prm_ready_o   = (phase_q == PH_SCORE);
  assign score_valid_o = (phase_q == PH_DRAIN);
  assign score_idx_o   = rd_cnt_q;
  assign frame_done_o  = done_q;

  assign obs_fire   = obs_valid_i && obs_ready_o;
  assign prm_fire   = prm_valid_i && prm_ready_o;
  assign out_fire   = score_valid_o && score_ready_i;
  assign is_const   = (elem_cnt_q == FIDX_W'(N_FEAT));
  assign first_beat = (elem_cnt_q == '0);
  assign last_load  = (load_cnt_q == FIDX_W'(N_FEAT - 1));
  assign last_state = (st_cnt_q == SIDX_W'(N_STATES - 1));
  assign last_drain = (rd_cnt_q == SIDX_W'(N_STATES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_LOAD;
      load_cnt_q <= '0;
      elem_cnt_q <= '0;
      st_cnt_q   <= '0;
      rd_cnt_q   <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_LOAD: if (obs_fire) begin
          if (last_load) begin
            load_cnt_q <= '0;
            phase_q    <= PH_SCORE;
          end else begin
            load_cnt_q <= load_cnt_q + FIDX_W'(1);
          end
        end
        PH_SCORE: if (prm_fire) begin
          if (is_const) begin
            elem_cnt_q <= '0;
            if (last_state) begin
              st_cnt_q <= '0;
              phase_q  <= PH_WAIT;
            end else begin
              st_cnt_q <= st_cnt_q + SIDX_W'(1);
            end
          end else begin
            elem_cnt_q <= elem_cnt_q + FIDX_W'(1);
          end
        end
        PH_WAIT: if (w_en && w_idx == SIDX_W'(N_STATES - 1)) begin
          phase_q <= PH_DRAIN;
          done_q  <= 1'b1;
        end
        PH_DRAIN: if (out_fire) begin
          if (last_drain) begin
            rd_cnt_q <= '0;
            phase_q  <= PH_LOAD;
          end else begin
            rd_cnt_q <= rd_cnt_q + SIDX_W'(1);
          end
        end
        default: phase_q <= PH_LOAD;
      endcase
    end
  end

  obs_vec_buf #(.N_FEAT(N_FEAT), .OBS_W(OBS_W), .IDX_W(FIDX_W)) u_vec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (obs_fire),
    .wr_idx_i  (load_cnt_q),
    .wr_data_i (obs_data_i),
    .rd_en_i   (prm_fire && !is_const),
    .rd_idx_i  (elem_cnt_q),
    .rd_data_o (rep_obs)
  );

  gauss_term_pipe #(
    .OBS_W(OBS_W), .WT_W(WT_W), .CONST_W(CONST_W), .TERM_W(TERM_W), .SIDX_W(SIDX_W)
  ) u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (prm_fire),
    .obs_i       (rep_obs),
    .mean_i      (prm_mean_i),
    .wt_i        (prm_wt_i),
    .cst_i       (prm_const_i),
    .is_const_i  (is_const),
    .first_i     (first_beat),
    .sidx_i      (st_cnt_q),
    .out_valid_o (t_valid),
    .term_o      (t_term),
    .first_o     (t_first),
    .last_o      (t_last),
    .sidx_o      (t_sidx)
  );

  score_acc #(
    .TERM_W(TERM_W), .ACC_W(ACC_W), .SCORE_W(SCORE_W), .OUT_SHIFT(OUT_SHIFT), .SIDX_W(SIDX_W)
  ) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (t_valid),
    .term_i     (t_term),
    .first_i    (t_first),
    .last_i     (t_last),
    .sidx_i     (t_sidx),
    .wr_en_o    (w_en),
    .wr_idx_o   (w_idx),
    .wr_score_o (w_score)
  );

  score_buf #(.N_STATES(N_STATES), .SCORE_W(SCORE_W), .SIDX_W(SIDX_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (w_en),
    .wr_idx_i  (w_idx),
    .wr_data_i (w_score),
    .rd_idx_i  (rd_cnt_q),
    .rd_data_o (score_o)
  );

  p_stable_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (score_valid_o && !score_ready_i) |=>
      (score_valid_o && $stable(score_o) && $stable(score_idx_o)));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
  p_done_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (score_valid_o && score_idx_o == '0));
  p_no_write_in_drain_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    score_valid_o |-> !w_en);
  p_state_starts_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_valid && t_last) |=> (w_en && w_idx == $past(t_sidx)));
endmodule

// File: tb/sim_log_gauss_scorer.sv
module sim_log_gauss_scorer;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 39;
  localparam int NS = 6;
  localparam int OBS_W = 12;
  localparam int WT_W = 12;
  localparam int CONST_W = 32;
  localparam int SCORE_W = 24;
  localparam int SH = 8;
  localparam int SIDX_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic obs_valid = 1'b0, obs_ready;
  logic signed [OBS_W-1:0] obs_data = '0;
  logic prm_valid = 1'b0, prm_ready;
  logic signed [OBS_W-1:0] prm_mean = '0;
  logic [WT_W-1:0] prm_wt = '0;
  logic signed [CONST_W-1:0] prm_const = '0;
  logic score_valid, score_ready = 1'b0;
  logic signed [SCORE_W-1:0] score;
  logic [SIDX_W-1:0] score_idx;
  logic frame_done;

  int checks = 0, fails = 0;
  longint obs_a [NF];
  longint mean_a [NS][NF];
  longint wt_a [NS][NF];
  longint cst_a [NS];
  longint got_a [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  log_gauss_scorer #(
    .N_FEAT(NF), .N_STATES(NS), .OBS_W(OBS_W), .WT_W(WT_W), .CONST_W(CONST_W),
    .ACC_W(48), .SCORE_W(SCORE_W), .OUT_SHIFT(SH)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .obs_valid_i(obs_valid), .obs_ready_o(obs_ready), .obs_data_i(obs_data),
    .prm_valid_i(prm_valid), .prm_ready_o(prm_ready),
    .prm_mean_i(prm_mean), .prm_wt_i(prm_wt), .prm_const_i(prm_const),
    .score_valid_o(score_valid), .score_ready_i(score_ready),
    .score_o(score), .score_idx_o(score_idx), .frame_done_o(frame_done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint expect_score(input int s);
    longint acc = cst_a[s];
    longint hi = (longint'(1) <<< (SCORE_W - 1)) - 1;
    longint lo = -hi - 1;
    for (int i = 0; i < NF; i++)
      acc += (obs_a[i] - mean_a[s][i]) * (obs_a[i] - mean_a[s][i]) * wt_a[s][i];
    acc = acc >>> SH;
    if (acc > hi) acc = hi;
    if (acc < lo) acc = lo;
    return acc;
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < NF; i++) begin
      obs_a[i] = ((i * 37 + seed * 11) % 400) - 200;
      for (int s = 0; s < NS; s++) begin
        mean_a[s][i] = ((i * 13 + s * 29 + seed) % 300) - 150;
        wt_a[s][i]   = ((i * 7 + s * 5 + seed) % 64) + 1;
      end
    end
    for (int s = 0; s < NS; s++) cst_a[s] = s * 1000 - 3000 + seed;
  endtask

  // drives one frame, with parameter offers during load and obs offers during scoring
  task automatic run_frame(input string tag, input int gap, input bit bp);
    int i = 0, b = 0, n = 0, hold = 0, guard = 0, dones = 0, early = 0;
    longint held_score = 0, held_idx = 0;
    bit seen = 0;
    // load
    while (i < NF) begin
      @(negedge clk);
      prm_valid = 1'b1; prm_mean = 12'sd777; prm_wt = 12'd999; prm_const = 32'sd12345;
      obs_valid = (gap == 0) || (i % 3 != 1) || (guard % 2 == 0);
      obs_data  = OBS_W'(obs_a[i]);
      guard++;
      #1;
      if (prm_ready) early++;
      if (obs_valid && obs_ready) i++;
    end
    @(negedge clk);
    obs_valid = 1'b0; prm_valid = 1'b0;
    #1;
    chk(early == 0, {tag, " R2 prm_ready low in load"}, early, 0);
    chk(!obs_ready && prm_ready, {tag, " R2 ready swap after load"}, {obs_ready, prm_ready}, 2'b01);
    // params
    early = 0;
    while (b < NS * (NF + 1)) begin
      int s = b / (NF + 1);
      int e = b % (NF + 1);
      @(negedge clk);
      obs_valid = 1'b1; obs_data = 12'sd1500;
      prm_valid = (gap == 0) || (b % 5 != 2) || (guard % 2 == 0);
      guard++;
      if (e < NF) begin
        prm_mean = OBS_W'(mean_a[s][e]); prm_wt = WT_W'(wt_a[s][e]); prm_const = 32'sh5A5A5A5;
      end else begin
        prm_mean = 12'sd1999; prm_wt = 12'hFFF; prm_const = CONST_W'(cst_a[s]);
      end
      #1;
      if (obs_ready || score_valid) early++;
      if (prm_valid && prm_ready) b++;
    end
    @(negedge clk);
    prm_valid = 1'b0; obs_valid = 1'b0;
    chk(early == 0, {tag, " R5 R7 obs_ready and score_valid low while scoring"}, early, 0);
    // drain
    guard = 0;
    while (n < NS && guard < 500) begin
      @(negedge clk);
      guard++;
      score_ready = !(bp && n == 2 && hold < 3);
      #1;
      if (frame_done) dones++;
      if (score_valid) begin
        if (!seen) begin
          chk(frame_done && score_idx == 0, {tag, " R8 done with first score"}, frame_done, 1);
          seen = 1;
        end
        if (score_ready) begin
          chk(score_idx == SIDX_W'(n), {tag, " R7 index order"}, score_idx, n);
          got_a[n] = score;
          n++;
        end else begin
          if (hold > 0)
            chk(score == held_score && score_idx == held_idx, {tag, " R9 held under backpressure"},
                score, held_score);
          held_score = score; held_idx = score_idx;
          hold++;
        end
      end
    end
    @(negedge clk);
    score_ready = 1'b0;
    #1;
    chk(n == NS, {tag, " R7 all scores drained"}, n, NS);
    chk(dones == 1 && !frame_done, {tag, " R8 single done pulse"}, dones, 1);
    chk(obs_ready && !score_valid && !prm_ready, {tag, " R10 back to load"}, obs_ready, 1);
    for (int s = 0; s < NS; s++)
      chk(got_a[s] == expect_score(s), {tag, " R3 R4 R5 R6 score"}, got_a[s], expect_score(s));
  endtask

  task automatic t_reset;
    #1;
    chk(obs_ready && !prm_ready && !score_valid && !frame_done, "R1 reset outputs",
        {obs_ready, prm_ready, score_valid, frame_done}, 4'b1000);
  endtask

  task automatic t_basic;
    fill(3);
    run_frame("basic", 0, 1'b0);
    fill(41);
    run_frame("basic2 R10", 0, 1'b0);
  endtask

  task automatic t_bubbles;
    fill(17);
    run_frame("bubbles R6 R9", 1, 1'b1);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < NF; i++) begin
      obs_a[i] = 2047;
      for (int s = 0; s < NS; s++) begin
        mean_a[s][i] = (s % 2 == 0) ? -2048 : 2047;
        wt_a[s][i]   = 4095;
      end
    end
    for (int s = 0; s < NS; s++) cst_a[s] = 100 * s;
    run_frame("saturate R4", 0, 1'b0);
    chk(got_a[0] == 64'sd8388607, "R4 positive saturation", got_a[0], 8388607);
    chk(got_a[1] == 64'sd0, "R6 R4 zero-distance neighbour", got_a[1], 0);
  endtask

  task automatic t_negative;
    for (int i = 0; i < NF; i++) begin
      obs_a[i] = i - 19;
      for (int s = 0; s < NS; s++) begin
        mean_a[s][i] = i - 19;
        wt_a[s][i]   = 50 + s;
      end
    end
    for (int s = 0; s < NS; s++) cst_a[s] = -1000 - 256 * s;
    run_frame("negative R4", 0, 1'b0);
    chk(got_a[0] == -64'sd4, "R3 R4 constant-only floor shift", got_a[0], -4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_bubbles();
    t_saturate();
    t_negative();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule